// File: doc/BRIEF.md
# Disk PIO Cycle Timer

This block times a single programmed-I/O transfer on a parallel disk bus. A requester raises a start request together with a direction flag (read or write) and a port-class flag. The port class picks one of two timing bytes: one for the data port and one for the command/control ports. Both drives on the channel share these two settings. At start, the chosen byte is decoded into three clock counts. The block then runs a setup phase, an active phase with the read or write strobe asserted, and a hold phase, and it signals completion with a one-clock done pulse.

A ready input from the drive can stretch the active phase when its enable input is set. While a transfer is running, the block reports busy and ignores new start requests. A transfer may be started in the same cycle that the previous one reports done, so cycles can follow each other with no gap.

Top module: `pio_cycle_timer`

## Requirements
- R1: After reset, addr_valid_o, rd_strobe_o, wr_strobe_o, busy_o and done_o are all low.
- R2: A start_i seen high at a clock edge while the block is idle gives a setup phase from that edge onward. In setup, addr_valid_o and busy_o are high and both strobes are low. Setup lasts 1, 2, 3 or 4 clocks for setup code 0, 1, 2 or 3.
- R3: The active phase follows setup. Its length is 2, 3, 4, 5, 6, 8, 12 or 16 clocks for active code 0 through 7.
- R4: The hold phase follows the active phase. Both strobes are low and addr_valid_o stays high. Hold lasts 1, 2, 3, 4, 5, 6, 8 or 12 clocks for hold code 0 through 7.
- R5: In the timing byte, the setup code is bits 7:6, the hold code is bits 5:3 and the active code is bits 2:0. Byte 0x00 gives 1/2/1 clocks (setup/active/hold) and byte 0xF5 gives 4/8/8.
- R6: port_cls_i = 0 selects data_timing_i and port_cls_i = 1 selects cmd_timing_i.
- R7: During the active phase, write_i = 1 at start asserts wr_strobe_o and write_i = 0 asserts rd_strobe_o. The two strobes are never high together.
- R8: done_o is high for exactly one clock, in the first clock after hold ends. In that clock, addr_valid_o and busy_o are already low.
- R9: The timing byte, port class and direction are captured at start. Changing them during a transfer has no effect on that transfer.
- R10: A start_i that arrives while busy_o is high is ignored: no extra transfer follows.
- R11: With iordy_en_i high, if iordy_i is low at the edge that would end the active phase, the active phase continues until an edge where iordy_i is high.
- R12: With iordy_en_i low, iordy_i has no effect on any phase length.
- R13: A start_i that is high at the edge right after done_o rises is accepted, so transfers run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one PIO transfer |
| write_i | input | 1 | 1 = write transfer, 0 = read transfer |
| port_cls_i | input | 1 | 0 = data port, 1 = command/control ports |
| data_timing_i | input | 8 | Timing byte for data-port transfers |
| cmd_timing_i | input | 8 | Timing byte for command/control transfers |
| iordy_en_i | input | 1 | Enables stretching of the active phase by iordy_i |
| iordy_i | input | 1 | Drive ready (synchronous to clk) |
| addr_valid_o | output | 1 | Address valid, from setup through hold |
| rd_strobe_o | output | 1 | Read strobe, high during a read's active phase |
| wr_strobe_o | output | 1 | Write strobe, high during a write's active phase |
| busy_o | output | 1 | A transfer is in progress |
| done_o | output | 1 | One-clock pulse when a transfer completes |

## Verification
The assertions check, on every cycle, the relations that do not depend on what was programmed:
- the two strobes are never high together;
- a strobe rises only out of an address-valid setup clock;
- an accepted start produces setup on the next clock;
- done is a lone pulse that follows a hold clock;
- a stalled active phase keeps its strobe.

The exact phase lengths for each setup, active and hold code need the bench's scenarios, which measure each phase at the ports and compare it with a value decoded independently. The same applies to the choice between the two timing bytes, the capture of settings at start, the rejection of starts while busy and the length of an IORDY stretch.

// File: rtl/pio_timer_pkg.sv
package pio_timer_pkg;

    localparam int CNT_W = 5;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] active;
        logic [CNT_W-1:0] hold;
    } phase_len_t;

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] act_len;
        logic [CNT_W-1:0] hold_len;
        logic             write;
        logic             done;
    } seq_st_t;

    function automatic logic [CNT_W-1:0] setup_clocks(input logic [1:0] code);
        return CNT_W'(code) + CNT_W'(1);
    endfunction

    function automatic logic [CNT_W-1:0] hold_clocks(input logic [2:0] code);
        logic [CNT_W-1:0] r;
        case (code)
            3'd6:    r = CNT_W'(8);
            3'd7:    r = CNT_W'(12);
            default: r = CNT_W'(code) + CNT_W'(1);
        endcase
        return r;
    endfunction

    function automatic logic [CNT_W-1:0] active_clocks(input logic [2:0] code);
        logic [CNT_W-1:0] r;
        case (code)
            3'd5:    r = CNT_W'(8);
            3'd6:    r = CNT_W'(12);
            3'd7:    r = CNT_W'(16);
            default: r = CNT_W'(code) + CNT_W'(2);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pio_timing_select.sv
module pio_timing_select #(
    parameter int N_CLASS = 2,
    parameter int BYTE_W  = 8,
    localparam int SEL_W  = (N_CLASS > 1) ? $clog2(N_CLASS) : 1
) (
    input  logic [N_CLASS-1:0][BYTE_W-1:0] tbytes_i,
    input  logic [SEL_W-1:0]               sel_i,
    output logic [BYTE_W-1:0]              tbyte_o
);

    always_comb begin
        tbyte_o = tbytes_i[0];
        for (int i = 1; i < N_CLASS; i++) begin
            if (sel_i == SEL_W'(i)) begin
                tbyte_o = tbytes_i[i];
            end
        end
    end

endmodule

// File: rtl/pio_timing_decode.sv
module pio_timing_decode
    import pio_timer_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] tbyte_i,
    output phase_len_t        len_o
);

    localparam int ACT_LSB   = 0;
    localparam int HOLD_LSB  = 3;
    localparam int SETUP_LSB = 6;

    logic [1:0] setup_code;
    logic [2:0] hold_code;
    logic [2:0] act_code;

    assign setup_code = tbyte_i[SETUP_LSB +: 2];
    assign hold_code  = tbyte_i[HOLD_LSB  +: 3];
    assign act_code   = tbyte_i[ACT_LSB   +: 3];

    always_comb begin
        len_o.setup  = setup_clocks(setup_code);
        len_o.active = active_clocks(act_code);
        len_o.hold   = hold_clocks(hold_code);
    end

endmodule

// File: rtl/pio_phase_seq.sv
module pio_phase_seq
    import pio_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       write_i,
    input  phase_len_t len_i,
    input  logic       iordy_en_i,
    input  logic       iordy_i,
    output phase_e     phase_o,
    output logic       write_o,
    output logic       done_o
);

    seq_st_t st_d, st_q;
    logic    cnt_last;
    logic    stall;

    assign cnt_last = (st_q.cnt == CNT_W'(1));
    assign stall    = iordy_en_i && !iordy_i;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.phase    = PH_SETUP;
                    st_d.cnt      = len_i.setup;
                    st_d.act_len  = len_i.active;
                    st_d.hold_len = len_i.hold;
                    st_d.write    = write_i;
                end
            end
            PH_SETUP: begin
                if (cnt_last) begin
                    st_d.phase = PH_ACTIVE;
                    st_d.cnt   = st_q.act_len;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
            PH_ACTIVE: begin
                if (cnt_last) begin
                    if (!stall) begin
                        st_d.phase = PH_HOLD;
                        st_d.cnt   = st_q.hold_len;
                    end
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
            PH_HOLD: begin
                if (cnt_last) begin
                    st_d.phase = PH_IDLE;
                    st_d.cnt   = '0;
                    st_d.done  = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cnt: '0, act_len: '0, hold_len: '0,
                      write: 1'b0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;
    assign write_o = st_q.write;
    assign done_o  = st_q.done;

endmodule

// File: rtl/pio_cycle_timer.sv
module pio_cycle_timer
    import pio_timer_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              write_i,
    input  logic              port_cls_i,
    input  logic [BYTE_W-1:0] data_timing_i,
    input  logic [BYTE_W-1:0] cmd_timing_i,
    input  logic              iordy_en_i,
    input  logic              iordy_i,
    output logic              addr_valid_o,
    output logic              rd_strobe_o,
    output logic              wr_strobe_o,
    output logic              busy_o,
    output logic              done_o
);

    localparam int N_CLASS = 2;

    logic [N_CLASS-1:0][BYTE_W-1:0] tbytes;
    logic [BYTE_W-1:0]              tbyte_sel;
    phase_len_t                     len;
    phase_e                         phase;
    logic                           write_q;

    assign tbytes[0] = data_timing_i;
    assign tbytes[1] = cmd_timing_i;

    pio_timing_select #(.N_CLASS(N_CLASS), .BYTE_W(BYTE_W)) sel_i (
        .tbytes_i (tbytes),
        .sel_i    (port_cls_i),
        .tbyte_o  (tbyte_sel)
    );

    pio_timing_decode #(.BYTE_W(BYTE_W)) dec_i (
        .tbyte_i (tbyte_sel),
        .len_o   (len)
    );

    pio_phase_seq seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .write_i    (write_i),
        .len_i      (len),
        .iordy_en_i (iordy_en_i),
        .iordy_i    (iordy_i),
        .phase_o    (phase),
        .write_o    (write_q),
        .done_o     (done_o)
    );

    assign addr_valid_o = (phase != PH_IDLE);
    assign busy_o       = (phase != PH_IDLE);
    assign rd_strobe_o  = (phase == PH_ACTIVE) && !write_q;
    assign wr_strobe_o  = (phase == PH_ACTIVE) &&  write_q;

endmodule

// File: rtl/pio_cycle_timer_chk.sv
module pio_cycle_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic iordy_en_i,
    input logic iordy_i,
    input logic addr_valid_o,
    input logic rd_strobe_o,
    input logic wr_strobe_o,
    input logic busy_o,
    input logic done_o
);

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_strobe_o && wr_strobe_o)); // R7

    AST_SETUP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (addr_valid_o && busy_o && !rd_strobe_o && !wr_strobe_o)); // R2

    AST_STROBE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_strobe_o || wr_strobe_o) |-> ($past(addr_valid_o) && !$past(done_o))); // R2

    AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8

    AST_DONE_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!addr_valid_o && !busy_o && $past(addr_valid_o)
                    && !$past(rd_strobe_o) && !$past(wr_strobe_o))); // R8

    AST_IORDY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_strobe_o || wr_strobe_o) && iordy_en_i && !iordy_i)
            |=> ($stable(rd_strobe_o) && $stable(wr_strobe_o))); // R11

endmodule

bind pio_cycle_timer pio_cycle_timer_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .iordy_en_i   (iordy_en_i),
    .iordy_i      (iordy_i),
    .addr_valid_o (addr_valid_o),
    .rd_strobe_o  (rd_strobe_o),
    .wr_strobe_o  (wr_strobe_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
);

// File: tb/pio_cycle_timer_tb_top.sv
module pio_cycle_timer_tb_top;

    typedef struct {
        int s;
        int a;
        int h;
        bit wr;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       write_i = 1'b0;
    logic       port_cls_i = 1'b0;
    logic [7:0] data_timing_i = 8'hF5;
    logic [7:0] cmd_timing_i = 8'hDE;
    logic       iordy_en_i = 1'b0;
    logic       iordy_i = 1'b1;
    logic       addr_valid_o, rd_strobe_o, wr_strobe_o, busy_o, done_o;

    int   n_checks = 0;
    int   n_fail   = 0;
    exp_t exp_q[$];
    bit   finished = 1'b0;

    always #2.5 clk = ~clk;

    pio_cycle_timer dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .write_i       (write_i),
        .port_cls_i    (port_cls_i),
        .data_timing_i (data_timing_i),
        .cmd_timing_i  (cmd_timing_i),
        .iordy_en_i    (iordy_en_i),
        .iordy_i       (iordy_i),
        .addr_valid_o  (addr_valid_o),
        .rd_strobe_o   (rd_strobe_o),
        .wr_strobe_o   (wr_strobe_o),
        .busy_o        (busy_o),
        .done_o        (done_o)
    );

    function automatic int exp_setup(input logic [7:0] b);
        return int'(b[7:6]) + 1;
    endfunction

    function automatic int exp_hold(input logic [7:0] b);
        case (b[5:3])
            3'd6:    return 8;
            3'd7:    return 12;
            default: return int'(b[5:3]) + 1;
        endcase
    endfunction

    function automatic int exp_active(input logic [7:0] b);
        case (b[2:0])
            3'd5:    return 8;
            3'd6:    return 12;
            3'd7:    return 16;
            default: return int'(b[2:0]) + 2;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string msg);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    // driver: push the expected phase lengths, then pulse start for one clock
    task automatic issue(input bit cls, input bit wr, input logic [7:0] db,
                         input logic [7:0] cb, input int act_override, input string tag);
        exp_t e;
        logic [7:0] b;
        b = cls ? cb : db;
        e.s = exp_setup(b);
        e.a = (act_override > 0) ? act_override : exp_active(b);
        e.h = exp_hold(b);
        e.wr = wr;
        e.tag = tag;
        exp_q.push_back(e);
        port_cls_i    = cls;
        write_i       = wr;
        data_timing_i = db;
        cmd_timing_i  = cb;
        start_i       = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done_o);
    endtask

    // monitor: measure each phase at the ports and compare with the queue head
    int  m_s = 0, m_a = 0, m_h = 0;
    bit  m_seen = 1'b0, m_rd = 1'b0, m_wr = 1'b0, m_stray = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (addr_valid_o && exp_q.size() == 0 && !m_stray) begin
                m_stray = 1'b1;
                check(1'b0, "R10", "transfer activity with no request outstanding (act 1, exp 0)");
            end
            if (rd_strobe_o || wr_strobe_o) begin
                m_seen = 1'b1;
                m_a++;
                if (rd_strobe_o) m_rd = 1'b1;
                if (wr_strobe_o) m_wr = 1'b1;
            end else if (addr_valid_o) begin
                if (m_seen) m_h++;
                else        m_s++;
            end
            if (done_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10", "done with empty scoreboard");
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(m_s == e.s && m_a == e.a && m_h == e.h && m_wr == e.wr && m_rd == !e.wr,
                          e.tag,
                          $sformatf("s/a/h/wr/rd act %0d/%0d/%0d/%0d/%0d exp %0d/%0d/%0d/%0d/%0d",
                                    m_s, m_a, m_h, m_wr, m_rd, e.s, e.a, e.h, e.wr, !e.wr));
                end
                m_s = 0; m_a = 0; m_h = 0;
                m_seen = 1'b0; m_rd = 1'b0; m_wr = 1'b0;
            end
        end
    end

    task automatic finish_run();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        int wd = 0;
        while (!finished) begin
            @(posedge clk);
            wd++;
            if (wd > 100000) begin
                check(1'b0, "R1", "watchdog expired (act hung, exp finish)");
                finish_run();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check({addr_valid_o, rd_strobe_o, wr_strobe_o, busy_o, done_o} == 5'b0, "R1",
              $sformatf("outputs in reset act %b exp 00000",
                        {addr_valid_o, rd_strobe_o, wr_strobe_o, busy_o, done_o}));
        rst_n = 1'b1;
        @(negedge clk);
        check({addr_valid_o, rd_strobe_o, wr_strobe_o, busy_o, done_o} == 5'b0, "R1",
              "outputs after reset release not all low");

        // R5: field positions, fastest and default bytes
        issue(1'b0, 1'b0, 8'h00, 8'hDE, 0, "R5");
        wait_done();
        issue(1'b0, 1'b1, 8'hF5, 8'hDE, 0, "R5");
        wait_done();

        // R2 R3 R4: sweep all codes, alternating class and direction (R6 R7)
        for (int i = 0; i < 8; i++) begin
            logic [7:0] b;
            b = {i[1:0], 3'(7 - i), i[2:0]};
            if (i % 2 == 0) issue(1'b0, i[1], b, 8'h00, 0, "R3_R4_R2");
            else            issue(1'b1, i[1], 8'hFF, b, 0, "R3_R4_R6");
            wait_done();
        end

        // R6: command class uses cmd byte while data byte differs
        issue(1'b1, 1'b0, 8'hF5, 8'hDE, 0, "R6");
        wait_done();

        // R9: change timing byte, class and direction during the transfer
        issue(1'b0, 1'b0, 8'h00, 8'h00, 0, "R9");
        data_timing_i = 8'hFF; cmd_timing_i = 8'hFF; write_i = 1'b1; port_cls_i = 1'b1;
        wait_done();

        // R10: start while busy is ignored
        issue(1'b0, 1'b1, 8'h49, 8'h00, 0, "R10");
        @(negedge clk);
        check(busy_o == 1'b1, "R10", $sformatf("busy act %0b exp 1", busy_o));
        data_timing_i = 8'h00; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done();
        begin
            bit idle_ok = 1'b1;
            repeat (6) begin
                @(negedge clk);
                if (addr_valid_o || busy_o) idle_ok = 1'b0;
            end
            check(idle_ok, "R10", $sformatf("bus active after ignored start act %0b exp 0", !idle_ok));
        end

        // R13: back-to-back start right after done
        issue(1'b0, 1'b0, 8'h08, 8'h00, 0, "R13");
        wait_done();
        issue(1'b1, 1'b1, 8'h00, 8'h51, 0, "R13");
        wait_done();

        // R11: IORDY enabled and low stretches active (byte 0x00: setup 1, active 2)
        iordy_en_i = 1'b1; iordy_i = 1'b0;
        issue(1'b0, 1'b0, 8'h00, 8'h00, 20, "R11");
        repeat (20) @(negedge clk);
        iordy_i = 1'b1;
        wait_done();
        // R11: IORDY enabled but high gives nominal timing
        issue(1'b0, 1'b1, 8'hF5, 8'h00, 0, "R11");
        wait_done();

        // R12: IORDY disabled, ready low has no effect
        iordy_en_i = 1'b0; iordy_i = 1'b0;
        issue(1'b1, 1'b0, 8'h00, 8'hDE, 0, "R12");
        wait_done();
        iordy_i = 1'b1;

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R8", $sformatf("outstanding items act %0d exp 0", exp_q.size()));
        finish_run();
    end

endmodule